// File: doc/BRIEF.md
# Byte-Lane Read/Write Strobe Generator

This block turns one internal bus request into the active-low strobes of an external data bus. The bus is 8 or 16 bits wide. A request carries a direction, an address LSB and an access size (byte or word). The block holds the matching strobe pattern for a fixed window of `STROBE_LEN` clock cycles. It then returns every pin to its idle level.

Two strobe conventions are supported:

- **Split style:** one write enable for the even byte lane and one for the odd byte lane.
- **Joint style:** a single write strobe, plus a byte-high enable and the address LSB, which together tell which lanes take part.

A configuration bit picks the style and resets to the joint style. When the width pin says the bus is 8 bits wide, the joint style is used whatever the bit holds. On such a bus a word request cannot be carried, so the block refuses it with an error pulse instead of splitting it.

Top module: `byte_strobe_gen`

## Requirements
- R1: `bus_narrow` = 0 selects a 16-bit external bus and `bus_narrow` = 1 selects an 8-bit bus.
- R2: In split style (`style_split` = 1, 16-bit bus), writes drive the lane strobes as follows: an even byte write (`req_addr0` = 0) drives only `wr_lo_n` low, an odd byte write drives only `wr_hi_n` low, and a word write drives both low.
- R3: In joint style on a 16-bit bus, `wr_lo_n` acts as the write strobe and is low for writes only. `wr_hi_n` acts as byte-high enable and is low when the odd lane takes part (odd byte or word). `addr0_out` is low when the even lane takes part (even byte or word). This applies to reads and writes alike.
- R4: On an 8-bit bus the joint style is forced regardless of the style bit, `wr_hi_n` stays high, and `addr0_out` follows `req_addr0`.
- R5: After reset the style bit is 0 (joint style) until a write through `cfg_we`.
- R6: A read drives `rd_n` low and never drives a write strobe low. In joint style that write strobe is `wr_lo_n`; in split style it is `wr_lo_n` and `wr_hi_n`. No write drives `rd_n` low.
- R7: Timing of the strobe window:
  - With no access in progress, `rd_n`, `wr_lo_n`, `wr_hi_n` and `addr0_out` are all 1 and `req_ready` is 1.
  - A request accepted at a clock edge shows its pattern from that edge for exactly `STROBE_LEN` cycles, with `req_ready` low over the same cycles.
- R8: A word request (`req_word` = 1) on an 8-bit bus is accepted but refused. `req_err` is high for one cycle after the accepting edge, no strobe goes low, and `req_ready` stays high.
- R9: A request presented while `req_ready` is low is ignored, and the pattern in progress is unchanged.
- R10: A word access ignores `req_addr0` and drives `addr0_out` low during its window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the style bit from `cfg_split` |
| cfg_split | input | 1 | Style value: 1 split lanes, 0 joint write/byte-high |
| bus_narrow | input | 1 | Width pin level: 0 = 16-bit, 1 = 8-bit |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr0 | input | 1 | Address LSB |
| req_word | input | 1 | 1 word access, 0 byte access |
| req_ready | output | 1 | Block idle; a request is taken at the next edge |
| req_err | output | 1 | One-cycle pulse: word request refused on 8-bit bus |
| rd_n | output | 1 | Read strobe, active low |
| wr_lo_n | output | 1 | Even-lane write (split) or write strobe (joint), active low |
| wr_hi_n | output | 1 | Odd-lane write (split) or byte-high enable (joint), active low |
| addr0_out | output | 1 | Address LSB on the bus; 1 while idle |

## Verification
The assertions take the width pin as static while a window is open, because the 8-bit-bus check ties `wr_hi_n` to the live pin level rather than to the level seen at acceptance. The stimulus respects this: it changes `bus_narrow` and the style bit only while the block is idle, and then sweeps every combination of width, style, direction, address LSB and size. A request held through a busy window checks that nothing can be started inside a window.

// File: rtl/bbs_pkg.sv
// Shared types for the byte-lane strobe generator.
// Assumes all bus pins are active low and idle at 1.
package bbs_pkg;
    typedef enum logic {
        STYLE_JOINT = 1'b0,
        STYLE_SPLIT = 1'b1
    } style_e;

    typedef struct packed {
        logic rd_n;
        logic lo_n;
        logic hi_n;
        logic a0;
    } pins_t;

    localparam pins_t PINS_IDLE = '{rd_n: 1'b1, lo_n: 1'b1, hi_n: 1'b1, a0: 1'b1};
endpackage

// File: rtl/bbs_style_reg.sv
// Holds the strobe-style configuration bit.
// Assumes cfg_we is a single-cycle write; resets to the joint style.
module bbs_style_reg
    import bbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cfg_we,
    input  logic   cfg_split,
    output style_e style_q
);
    // Load the style on a config write; joint style after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      style_q <= STYLE_JOINT;
        else if (cfg_we) style_q <= cfg_split ? STYLE_SPLIT : STYLE_JOINT;
    end
endmodule

// File: rtl/bbs_lane_decode.sv
// Combinational decode of one request into a strobe pattern.
// Assumes the caller only uses the pattern when err_o is low.
module bbs_lane_decode
    import bbs_pkg::*;
(
    input  style_e style_i,
    input  logic   narrow_i,
    input  logic   write_i,
    input  logic   addr0_i,
    input  logic   word_i,
    output pins_t  pins_o,
    output logic   err_o
);
    logic split_eff;
    logic even_used;
    logic odd_used;

    // Decide which lanes take part and whether the split style applies.
    always_comb begin
        split_eff = (style_i == STYLE_SPLIT) && !narrow_i;
        even_used = word_i || !addr0_i;
        odd_used  = word_i ||  addr0_i;
        err_o     = narrow_i && word_i;
    end

    // Build the active-low pin pattern for the selected style.
    always_comb begin
        pins_o      = PINS_IDLE;
        pins_o.rd_n = write_i;
        pins_o.a0   = word_i ? 1'b0 : addr0_i;
        if (split_eff) begin
            pins_o.lo_n = !(write_i && even_used);
            pins_o.hi_n = !(write_i && odd_used);
        end else begin
            pins_o.lo_n = !write_i;
            pins_o.hi_n = narrow_i ? 1'b1 : !odd_used;
        end
    end
endmodule

// File: rtl/bbs_window.sv
// Holds a strobe pattern for STROBE_LEN cycles, then returns to idle.
// Assumes start_i is only raised while active_o is low.
module bbs_window
    import bbs_pkg::*;
#(
    parameter int STROBE_LEN = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  pins_t pins_i,
    output pins_t pins_q,
    output logic  active_o
);
    localparam int CNT_W = (STROBE_LEN > 1) ? $clog2(STROBE_LEN) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(STROBE_LEN - 1);

    logic [CNT_W-1:0] remain_q;

    // Count down the window and drive or release the registered pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            remain_q <= '0;
            pins_q   <= PINS_IDLE;
        end else if (start_i) begin
            active_o <= 1'b1;
            remain_q <= LOAD;
            pins_q   <= pins_i;
        end else if (active_o) begin
            if (remain_q == '0) begin
                active_o <= 1'b0;
                pins_q   <= PINS_IDLE;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/byte_strobe_gen.sv
// Top: accepts one request while idle and refuses word requests on an 8-bit bus.
// Assumes bus_narrow is static while a window is open.
module byte_strobe_gen
    import bbs_pkg::*;
#(
    parameter int STROBE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_split,
    input  logic bus_narrow,
    input  logic req_valid,
    input  logic req_write,
    input  logic req_addr0,
    input  logic req_word,
    output logic req_ready,
    output logic req_err,
    output logic rd_n,
    output logic wr_lo_n,
    output logic wr_hi_n,
    output logic addr0_out
);
    style_e style_q;
    pins_t  dec_pins;
    pins_t  win_pins;
    logic   dec_err;
    logic   active;
    logic   accept;

    bbs_style_reg u_style (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_split (cfg_split),
        .style_q   (style_q)
    );

    bbs_lane_decode u_dec (
        .style_i  (style_q),
        .narrow_i (bus_narrow),
        .write_i  (req_write),
        .addr0_i  (req_addr0),
        .word_i   (req_word),
        .pins_o   (dec_pins),
        .err_o    (dec_err)
    );

    // A request is taken only while no window is open.
    always_comb begin
        accept = req_valid && !active;
    end

    bbs_window #(.STROBE_LEN(STROBE_LEN)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept && !dec_err),
        .pins_i   (dec_pins),
        .pins_q   (win_pins),
        .active_o (active)
    );

    // One-cycle refusal pulse for word requests on an 8-bit bus.
    always_ff @(posedge clk) begin
        if (!rst_n) req_err <= 1'b0;
        else        req_err <= accept && dec_err;
    end

    // Drive the ports from the window register.
    always_comb begin
        req_ready = !active;
        rd_n      = win_pins.rd_n;
        wr_lo_n   = win_pins.lo_n;
        wr_hi_n   = win_pins.hi_n;
        addr0_out = win_pins.a0;
    end
endmodule

// File: rtl/byte_strobe_gen_chk.sv
// Checker for byte_strobe_gen; attached by bind below.
// Assumes bus_narrow is static while a window is open.
module byte_strobe_gen_chk
    import bbs_pkg::*;
#(
    parameter int STROBE_LEN = 3
) (
    input logic   clk,
    input logic   rst_n,
    input logic   bus_narrow,
    input logic   req_ready,
    input logic   req_err,
    input logic   rd_n,
    input logic   wr_lo_n,
    input logic   wr_hi_n,
    input logic   addr0_out,
    input style_e style_q
);
    localparam int WC_W = $clog2(STROBE_LEN + 2) + 1;
    logic [WC_W-1:0] busy_cnt;

    // Count consecutive busy cycles to bound the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_cnt <= '0;
        else if (!req_ready) busy_cnt <= busy_cnt + 1'b1;
        else                 busy_cnt <= '0;
    end

    AST_READ_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> wr_lo_n); // R6
    AST_SPLIT_READ:  assert property (@(posedge clk) disable iff (!rst_n) (!rd_n && style_q == STYLE_SPLIT && !bus_narrow) |-> wr_hi_n); // R6
    AST_IDLE_HIGH:   assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (rd_n && wr_lo_n && wr_hi_n && addr0_out)); // R7
    AST_WINDOW_LEN:  assert property (@(posedge clk) disable iff (!rst_n) !req_ready |-> (busy_cnt < WC_W'(STROBE_LEN))); // R7
    AST_NARROW_BHE:  assert property (@(posedge clk) disable iff (!rst_n) bus_narrow |-> wr_hi_n); // R4
    AST_ERR_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) req_err |-> (req_ready && rd_n && wr_lo_n && wr_hi_n)); // R8
    AST_RESET_STYLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (style_q == STYLE_JOINT)); // R5
endmodule

bind byte_strobe_gen byte_strobe_gen_chk #(.STROBE_LEN(STROBE_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_narrow (bus_narrow),
    .req_ready  (req_ready),
    .req_err    (req_err),
    .rd_n       (rd_n),
    .wr_lo_n    (wr_lo_n),
    .wr_hi_n    (wr_hi_n),
    .addr0_out  (addr0_out),
    .style_q    (style_q)
);

// File: tb/byte_strobe_gen_tb.sv
`timescale 1ns/1ps
module byte_strobe_gen_tb;
    localparam int LEN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_split = 1'b0, bus_narrow = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_addr0 = 1'b0, req_word = 1'b0;
    logic req_ready, req_err, rd_n, wr_lo_n, wr_hi_n, addr0_out;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    byte_strobe_gen #(.STROBE_LEN(LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_split(cfg_split),
        .bus_narrow(bus_narrow), .req_valid(req_valid), .req_write(req_write),
        .req_addr0(req_addr0), .req_word(req_word), .req_ready(req_ready),
        .req_err(req_err), .rd_n(rd_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
        .addr0_out(addr0_out)
    );

    task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] obs();
        return {req_ready, req_err, rd_n, wr_lo_n, wr_hi_n, addr0_out};
    endfunction

    // Expected {rd_n, lo, hi, a0} from the requirements.
    function automatic logic [3:0] expect_pins(bit nar, bit spl, bit wr, bit a0, bit wd);
        bit even = wd || !a0;
        bit odd  = wd || a0;
        bit ea0  = wd ? 1'b0 : a0;
        if (spl && !nar) return {wr, !(wr && even), !(wr && odd), ea0};   // R2
        return {wr, !wr, nar ? 1'b1 : !odd, ea0};                          // R3 R4
    endfunction

    task automatic set_style(bit s);
        @(negedge clk); cfg_we = 1'b1; cfg_split = s;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // One access; when hold is set the request stays up through the window (R9).
    task automatic run_one(string tag, bit nar, bit spl, bit wr, bit a0, bit wd, bit hold);
        logic [3:0] ep = expect_pins(nar, spl, wr, a0, wd);
        bus_narrow = nar;
        req_valid = 1'b1; req_write = wr; req_addr0 = a0; req_word = wd;
        @(negedge clk);
        if (nar && wd) begin
            req_valid = 1'b0;
            chk({tag, " R8 refuse"}, obs(), 6'b11_1111);
            @(negedge clk);
            chk({tag, " R8 after"}, obs(), 6'b10_1111);
        end else begin
            if (hold) begin req_write = !wr; req_addr0 = !a0; end
            else req_valid = 1'b0;
            chk({tag, " R1 R2 R3 R4 R6 R10 first"}, obs(), {2'b00, ep});
            for (int k = 1; k < LEN; k++) begin
                if (k == LEN - 1) req_valid = 1'b0;
                @(negedge clk);
                chk({tag, hold ? " R9 held" : " R7 held"}, obs(), {2'b00, ep});
            end
            @(negedge clk);
            chk({tag, " R7 idle"}, obs(), 6'b10_1111);
        end
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset idle", obs(), 6'b10_1111);
        // R5: no config write yet, odd byte write must use joint style
        run_one("R5 reset style", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        n_chk++;
        if ({rd_n, wr_lo_n} !== 2'b11) begin
            n_bad++; $display("FAIL R5 post %b expected 11", {rd_n, wr_lo_n});
        end
        for (int s = 0; s < 2; s++) begin
            set_style(s[0]);
            for (int v = 0; v < 16; v++) begin
                run_one($sformatf("sweep s%0d v%0d", s, v), v[3], s[0], v[2], v[1], v[0], 1'b0);
            end
        end
        // R9: request held through busy window in both styles
        set_style(1'b1);
        run_one("R9 split", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        set_style(1'b0);
        run_one("R9 joint", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        // R4: narrow bus with split bit set still behaves joint
        set_style(1'b1);
        run_one("R4 forced", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule